// File: doc/BRIEF.md
# Five-Output Clock Routing and Enable Controller

The block routes a reference clock and two VCO clocks to five clock pads, each behind its own divider, and governs how those pads behave when they are disabled. Every clock source arrives as a tick strobe in the block's clock domain, and each tick marks one half-period of that source. Each output counts ticks of its selected source and toggles its level after a programmed number of them. The outputs are therefore the source divided by a 5-bit integer P, odd or even, optionally multiplied by a post factor of 1, 2, 4 or 8. The result is always a 50 % duty clock.

Two full configuration sets are loaded through a simple write port of address, data and strobe. Only one set drives the outputs at a time. A selection input chooses it, and a change of set is applied only after the selection has held still for a programmable number of cycles. One pad pin can be given up to serve as the master output-enable input or the power-down input, or another pad as the configuration-select input. The master enable stops outputs only during their low phase, so no runt pulse is produced. Power-down acts at once, without waiting for a clock edge: it drops the oscillator, PLL and divider enables and clears every divider. For both the master enable and power-down, the disabled pad state is programmed as floating or as driven low.

Top module: `clkrt_top`

## Requirements
- R1: Output 0 follows the second VCO tick stream and toggles its level after every P of those ticks. The post factor does not apply to it, and P=0 acts as P=1.
- R2: Output 4 follows the reference tick stream and toggles after every P ticks, with no post factor.
- R3: Output 2 follows the reference and toggles after every P*2^post ticks.
- R4: Outputs 1 and 3 toggle after every P*2^post ticks of their source. The source is the reference when the register's source bit is 1. When the bit is 0 it is the first VCO for output 1 and the second VCO for output 3.
- R5: Register map. Write address bit 3 picks set 0 or 1. Low index 0..4 holds output n's settings: data[4:0]=P, [6:5]=post exponent, [7]=source bit. Index 5 holds the disabled-state types: [0]=1 means master-enable-off drives low, [1]=1 means power-down drives low, and 0 means floating. Index 6 is global and holds data[1:0], the pin-sharing mode: 0 none, 1 master enable on pad 2, 2 power-down on pad 2, 3 config select on pad 4. Index 7 is global and holds the settle count. Reset gives P=1, post 0, source bit 0, both types floating, sharing 0 and settle 8.
- R6: In sharing mode 1, pad 2 is an input (pad enable 0). When the master enable is 0, each output, once low, shows pad enable equal to the type bit and value 0. If its level is already low, this happens 3 cycles after the input change. Returning the enable to 1 restores the outputs.
- R7: An output whose level is high when the master enable drops keeps running until its level falls. It is disabled at the following edge.
- R8: In sharing mode 2, pad 2 is an input. A 0 on the power-down input forces the oscillator, PLL and divider enables to 0 without waiting for a clock edge. Every pad goes floating or driven low according to the power-down type bit, and all dividers restart from zero when the input returns to 1.
- R9: In sharing mode 3, pad 4 is an input. The applied set equals the synchronized select value once that value has held still for more than the settle count.
- R10: A select pulse shorter than the settle count leaves the applied set unchanged.
- R11: In sharing mode 0, the master-enable, power-down and select inputs have no effect, and set 1 stays applied.
- R12: Reset leaves every pad enabled and driving 0, and all three core enables at 1.
- R13: A write to the applied set reaches the outputs at the next settle window, without any change of the select input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; all tick strobes are in this domain |
| rst | input | 1 | Synchronous active-high reset |
| ref_tick | input | 1 | Reference half-period strobe |
| vco1_tick | input | 1 | First VCO half-period strobe |
| vco2_tick | input | 1 | Second VCO half-period strobe |
| cfg_sel_in | input | 1 | Configuration select (asynchronous) |
| oe_master_in | input | 1 | Master output enable, 1 = run (asynchronous) |
| pwr_on_in | input | 1 | 0 = power down, 1 = run (asynchronous) |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address: bit 3 set, bits 2:0 index |
| wr_data | input | 8 | Register write data |
| osc_en | output | 1 | Oscillator enable |
| pll_en | output | 2 | PLL enables, one per PLL |
| div_en | output | 1 | Divider enable |
| clk_oe | output | 5 | Pad drive enable per output |
| clk_val | output | 5 | Pad drive value per output |

## Verification
A divider level changes one edge after the tick that completes its count. The bench drives ticks on the falling edge and compares every output level on the next falling edge, against a tick count kept per source. A master-enable change passes two synchronizer flops and the gate register, so it shows three edges later. The bench checks both the second and the third edge, and with a high level it checks the edge after the fall as well. Power-down is checked one time unit after the input moves, with no edge in between, and select changes are checked only after twenty cycles, well beyond the two synchronizer stages and a four-cycle settle window.

// File: rtl/clkrt_pkg.sv
package clkrt_pkg;

    localparam int NOUT    = 5;
    localparam int P_W     = 5;
    localparam int POST_W  = 2;
    localparam int ADDR_W  = 4;
    localparam int DATA_W  = 8;
    localparam int MAXSH   = (1 << POST_W) - 1;
    localparam int CNT_W   = P_W + MAXSH;
    localparam int IDX_TYPES  = 5;
    localparam int IDX_SHARE  = 6;
    localparam int IDX_SETTLE = 7;

    typedef struct packed {
        logic              src_ref;
        logic [POST_W-1:0] post;
        logic [P_W-1:0]    pdiv;
    } outcfg_t;

    typedef struct packed {
        outcfg_t [NOUT-1:0] outs;
        logic               pd_lo;
        logic               oe_lo;
    } cfgset_t;

    typedef enum logic [1:0] {
        SH_NONE = 2'd0,
        SH_OEM  = 2'd1,
        SH_PDN  = 2'd2,
        SH_CSEL = 2'd3
    } share_e;

    typedef enum logic [1:0] {
        SRC_REF  = 2'd0,
        SRC_VCO1 = 2'd1,
        SRC_VCO2 = 2'd2
    } src_e;

    function automatic src_e pick_src(int idx, logic use_ref);
        case (idx)
            0:       return SRC_VCO2;
            1:       return use_ref ? SRC_REF : SRC_VCO1;
            3:       return use_ref ? SRC_REF : SRC_VCO2;
            default: return SRC_REF;
        endcase
    endfunction

    function automatic logic has_post(int idx);
        return (idx >= 1) && (idx <= 3);
    endfunction

    function automatic logic [CNT_W-1:0] div_len(outcfg_t c, logic post_ok);
        logic [CNT_W-1:0] base;
        base = (c.pdiv == '0) ? CNT_W'(1) : CNT_W'(c.pdiv);
        return post_ok ? (base << c.post) : base;
    endfunction

    function automatic cfgset_t set_default();
        cfgset_t s;
        for (int o = 0; o < NOUT; o++) begin
            s.outs[o].src_ref = 1'b0;
            s.outs[o].post    = '0;
            s.outs[o].pdiv    = P_W'(1);
        end
        s.pd_lo = 1'b0;
        s.oe_lo = 1'b0;
        return s;
    endfunction

    function automatic logic pin_is_input(int idx, share_e sh);
        if (idx == 2) return (sh == SH_OEM) || (sh == SH_PDN);
        if (idx == 4) return (sh == SH_CSEL);
        return 1'b0;
    endfunction

endpackage

// File: rtl/clkrt_sync.sv
module clkrt_sync #(
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic meta_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= RST_VAL;
            q      <= RST_VAL;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end
endmodule

// File: rtl/clkrt_regs.sv
module clkrt_regs
    import clkrt_pkg::*;
#(
    parameter int SETTLE_W   = DATA_W,
    parameter int SETTLE_RST = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [DATA_W-1:0]   wr_data,
    output cfgset_t [1:0]       sets_q,
    output share_e              share_q,
    output logic [SETTLE_W-1:0] settle_q
);
    localparam int IDX_W = ADDR_W - 1;
    localparam int OC_W  = $bits(outcfg_t);

    logic [IDX_W-1:0] idx;
    logic             bank;

    assign idx  = wr_addr[IDX_W-1:0];
    assign bank = wr_addr[ADDR_W-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < 2; s++) sets_q[s] <= set_default();
            share_q  <= SH_NONE;
            settle_q <= SETTLE_W'(SETTLE_RST);
        end else if (wr_en) begin
            for (int s = 0; s < 2; s++) begin
                if (bank == 1'(s)) begin
                    for (int o = 0; o < NOUT; o++) begin
                        if (idx == IDX_W'(o))
                            sets_q[s].outs[o] <= outcfg_t'(wr_data[OC_W-1:0]);
                    end
                    if (idx == IDX_W'(IDX_TYPES)) begin
                        sets_q[s].oe_lo <= wr_data[0];
                        sets_q[s].pd_lo <= wr_data[1];
                    end
                end
            end
            if (idx == IDX_W'(IDX_SHARE))  share_q  <= share_e'(wr_data[1:0]);
            if (idx == IDX_W'(IDX_SETTLE)) settle_q <= wr_data[SETTLE_W-1:0];
        end
    end
endmodule

// File: rtl/clkrt_cfgsel.sv
module clkrt_cfgsel
    import clkrt_pkg::*;
#(
    parameter int SETTLE_W = DATA_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cfg_sel_in,
    input  share_e              share,
    input  logic [SETTLE_W-1:0] settle,
    input  cfgset_t [1:0]       sets,
    output cfgset_t             active_q,
    output logic                act_sel_q,
    output logic                csel_s
);
    logic                sel_raw;
    logic                prev_q;
    logic [SETTLE_W-1:0] cnt_q;

    // select input only counts when its pin is given to that function
    assign sel_raw = (share == SH_CSEL) ? cfg_sel_in : 1'b1;

    clkrt_sync #(.RST_VAL(1'b1)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (sel_raw),
        .q   (csel_s)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q    <= 1'b1;
            cnt_q     <= '0;
            act_sel_q <= 1'b1;
            active_q  <= set_default();
        end else begin
            prev_q <= csel_s;
            if (csel_s != prev_q) begin
                cnt_q <= '0;
            end else if (cnt_q >= settle) begin
                // settle window closed: reload the shadow set
                cnt_q     <= '0;
                act_sel_q <= csel_s;
                active_q  <= sets[csel_s];
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/clkrt_outdiv.sv
module clkrt_outdiv
    import clkrt_pkg::*;
#(
    parameter int IDX = 0
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    clr,
    input  logic    ref_tick,
    input  logic    vco1_tick,
    input  logic    vco2_tick,
    input  outcfg_t cfg,
    input  logic    want_en,
    input  logic    lo_type,
    output logic    level_q,
    output logic    gate_q,
    output logic    run_oe,
    output logic    run_val
);
    localparam logic POST_OK = has_post(IDX);

    src_e             src_w;
    logic             tick_w;
    logic [CNT_W-1:0] len_w;
    logic [CNT_W-1:0] cnt_q;

    always_comb begin
        src_w = pick_src(IDX, cfg.src_ref);
        case (src_w)
            SRC_VCO1: tick_w = vco1_tick;
            SRC_VCO2: tick_w = vco2_tick;
            default:  tick_w = ref_tick;
        endcase
        len_w = div_len(cfg, POST_OK);
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt_q   <= '0;
            level_q <= 1'b0;
        end else if (tick_w) begin
            if (cnt_q >= len_w - CNT_W'(1)) begin
                cnt_q   <= '0;
                level_q <= ~level_q;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // enable changes only while the output sits low
    always_ff @(posedge clk) begin
        if (rst)           gate_q <= 1'b1;
        else if (!level_q) gate_q <= want_en;
    end

    assign run_oe  = gate_q | lo_type;
    assign run_val = gate_q & level_q;
endmodule

// File: rtl/clkrt_top.sv
module clkrt_top
    import clkrt_pkg::*;
#(
    parameter int SETTLE_RST = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ref_tick,
    input  logic              vco1_tick,
    input  logic              vco2_tick,
    input  logic              cfg_sel_in,
    input  logic              oe_master_in,
    input  logic              pwr_on_in,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              osc_en,
    output logic [1:0]        pll_en,
    output logic              div_en,
    output logic [NOUT-1:0]   clk_oe,
    output logic [NOUT-1:0]   clk_val
);
    localparam int SETTLE_W = DATA_W;

    cfgset_t [1:0]       sets_w;
    share_e              share_w;
    logic [SETTLE_W-1:0] settle_w;
    cfgset_t             active_w;
    logic                act_sel_w;
    logic                csel_s_w;
    logic                oem_s_w;
    logic                pd_act;
    logic                oem_ok;
    logic [NOUT-1:0]     level_w;
    logic [NOUT-1:0]     gate_w;
    logic [NOUT-1:0]     run_oe_w;
    logic [NOUT-1:0]     run_val_w;

    clkrt_regs #(.SETTLE_W(SETTLE_W), .SETTLE_RST(SETTLE_RST)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .sets_q   (sets_w),
        .share_q  (share_w),
        .settle_q (settle_w)
    );

    clkrt_cfgsel #(.SETTLE_W(SETTLE_W)) u_cfgsel (
        .clk        (clk),
        .rst        (rst),
        .cfg_sel_in (cfg_sel_in),
        .share      (share_w),
        .settle     (settle_w),
        .sets       (sets_w),
        .active_q   (active_w),
        .act_sel_q  (act_sel_w),
        .csel_s     (csel_s_w)
    );

    clkrt_sync #(.RST_VAL(1'b1)) u_oem_sync (
        .clk (clk),
        .rst (rst),
        .d   (oe_master_in),
        .q   (oem_s_w)
    );

    // power-down bypasses every register on its way to the pads
    assign pd_act = (share_w == SH_PDN) && !pwr_on_in;
    assign oem_ok = (share_w != SH_OEM) || oem_s_w;

    assign osc_en = !pd_act;
    assign pll_en = {2{!pd_act}};
    assign div_en = !pd_act;

    for (genvar i = 0; i < NOUT; i++) begin : g_out
        clkrt_outdiv #(.IDX(i)) u_div (
            .clk       (clk),
            .rst       (rst),
            .clr       (pd_act),
            .ref_tick  (ref_tick),
            .vco1_tick (vco1_tick),
            .vco2_tick (vco2_tick),
            .cfg       (active_w.outs[i]),
            .want_en   (oem_ok),
            .lo_type   (active_w.oe_lo),
            .level_q   (level_w[i]),
            .gate_q    (gate_w[i]),
            .run_oe    (run_oe_w[i]),
            .run_val   (run_val_w[i])
        );

        always_comb begin
            if (pin_is_input(i, share_w)) begin
                clk_oe[i]  = 1'b0;
                clk_val[i] = 1'b0;
            end else if (pd_act) begin
                clk_oe[i]  = active_w.pd_lo;
                clk_val[i] = 1'b0;
            end else begin
                clk_oe[i]  = run_oe_w[i];
                clk_val[i] = run_val_w[i];
            end
        end
    end
endmodule

// File: rtl/clkrt_chk.sv
module clkrt_chk
    import clkrt_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic [1:0]      share,
    input logic            pwr_on_in,
    input logic            osc_en,
    input logic [1:0]      pll_en,
    input logic            div_en,
    input logic [NOUT-1:0] clk_oe,
    input logic [NOUT-1:0] level,
    input logic [NOUT-1:0] gate,
    input logic            act_sel,
    input logic            csel_s
);
    a_r8_core_off: assert property (@(posedge clk) disable iff (rst)
        (share == SH_PDN && !pwr_on_in) |-> (!osc_en && pll_en == 2'b00 && !div_en));

    // R6 and R8: pad 2 becomes an input pin
    a_r6_pad2_input: assert property (@(posedge clk) disable iff (rst)
        (share == SH_OEM || share == SH_PDN) |-> !clk_oe[2]);

    a_r9_pad4_input: assert property (@(posedge clk) disable iff (rst)
        (share == SH_CSEL) |-> !clk_oe[4]);

    a_r9_switch_follows_sync: assert property (@(posedge clk) disable iff (rst)
        !$stable(act_sel) |-> (act_sel == $past(csel_s)));

    for (genvar i = 0; i < NOUT; i++) begin : g_gate
        a_r7_gate_at_low: assert property (@(posedge clk) disable iff (rst)
            $fell(gate[i]) |-> !$past(level[i]));
    end
endmodule

bind clkrt_top clkrt_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .share     (share_w),
    .pwr_on_in (pwr_on_in),
    .osc_en    (osc_en),
    .pll_en    (pll_en),
    .div_en    (div_en),
    .clk_oe    (clk_oe),
    .level     (level_w),
    .gate      (gate_w),
    .act_sel   (act_sel_w),
    .csel_s    (csel_s_w)
);

// File: tb/sim_clkrt_top.sv
module sim_clkrt_top;
    import clkrt_pkg::*;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ref_tick = 1'b0, vco1_tick = 1'b0, vco2_tick = 1'b0;
    logic       cfg_sel_in = 1'b1, oe_master_in = 1'b1, pwr_on_in = 1'b1;
    logic       wr_en = 1'b0;
    logic [3:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       osc_en, div_en;
    logic [1:0] pll_en;
    logic [4:0] clk_oe, clk_val;

    int tests = 0, fails = 0;
    int nref, nv1, nv2;
    int e_p, e_post, e_src;

    always #5 clk = ~clk;

    clkrt_top u0 (
        .clk (clk), .rst (rst),
        .ref_tick (ref_tick), .vco1_tick (vco1_tick), .vco2_tick (vco2_tick),
        .cfg_sel_in (cfg_sel_in), .oe_master_in (oe_master_in), .pwr_on_in (pwr_on_in),
        .wr_en (wr_en), .wr_addr (wr_addr), .wr_data (wr_data),
        .osc_en (osc_en), .pll_en (pll_en), .div_en (div_en),
        .clk_oe (clk_oe), .clk_val (clk_val)
    );

    task automatic check(input string tag, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        ref_tick = 0; vco1_tick = 0; vco2_tick = 0;
        cfg_sel_in = 1; oe_master_in = 1; pwr_on_in = 1;
        step(3);
        rst = 1'b0;
        nref = 0; nv1 = 0; nv2 = 0;
    endtask

    task automatic pulse(input int which);
        if (which == 0) ref_tick = 1; else if (which == 1) vco1_tick = 1; else vco2_tick = 1;
        step(1);
        ref_tick = 0; vco1_tick = 0; vco2_tick = 0;
    endtask

    function automatic int exp_level(input int i);
        int p, n, cnt;
        p = (e_p == 0) ? 1 : e_p;
        n = (i >= 1 && i <= 3) ? (p << e_post) : p;
        case (i)
            0: cnt = nv2;
            1: cnt = e_src ? nref : nv1;
            3: cnt = e_src ? nref : nv2;
            default: cnt = nref;
        endcase
        return (cnt / n) % 2;
    endfunction

    task automatic run_div(input int len);
        string tags [5];
        tags[0] = "R1"; tags[1] = "R4"; tags[2] = "R3"; tags[3] = "R4"; tags[4] = "R2";
        for (int c = 0; c < len; c++) begin
            ref_tick  = 1'b1;
            vco1_tick = (c % 2 == 0);
            vco2_tick = (c % 3 != 0);
            @(negedge clk);
            nref += 1; nv1 += int'(vco1_tick); nv2 += int'(vco2_tick);
            for (int i = 0; i < 5; i++)
                check({tags[i], " R5 R13 divided level"}, int'(clk_val[i]), exp_level(i));
        end
        ref_tick = 0; vco1_tick = 0; vco2_tick = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int plist [5];
        plist[0] = 1; plist[1] = 2; plist[2] = 3; plist[3] = 7; plist[4] = 31;

        // R12: reset state
        do_reset();
        check("R12 pad enables", int'(clk_oe), 5'h1F);
        check("R12 pad values", int'(clk_val), 0);
        check("R12 core enables", int'({osc_en, pll_en, div_en}), 4'hF);

        // R1..R5, R13: sweep of dividers written into the applied set
        for (int pi = 0; pi < 5; pi++) begin
            for (int po = 0; po < 4; po++) begin
                for (int sr = 0; sr < 2; sr++) begin
                    do_reset();
                    e_p = plist[pi]; e_post = po; e_src = sr;
                    for (int o = 0; o < 5; o++)
                        wr(4'(8 + o), {1'(sr), 2'(po), 5'(plist[pi])});
                    step(12);
                    run_div(4 * (plist[pi] << po) + 6);
                end
            end
        end
        // P=0 acts as 1
        do_reset();
        e_p = 0; e_post = 2; e_src = 0;
        for (int o = 0; o < 5; o++) wr(4'(8 + o), {1'b0, 2'd2, 5'd0});
        step(12);
        run_div(30);

        // R11: sharing mode 0 ignores the three control inputs
        do_reset();
        wr(4'h0, 8'h02);
        oe_master_in = 0; pwr_on_in = 0; cfg_sel_in = 0;
        step(20);
        check("R11 pads stay enabled", int'(clk_oe), 5'h1F);
        check("R11 core stays on", int'({osc_en, pll_en, div_en}), 4'hF);
        pulse(2);
        check("R11 set 1 still applied", int'(clk_val[0]), 1);
        oe_master_in = 1; pwr_on_in = 1; cfg_sel_in = 1;

        // R6, R7: master enable on pad 2
        do_reset();
        wr(4'h6, 8'h01);
        check("R6 pad 2 input", int'(clk_oe[2]), 0);
        oe_master_in = 0;
        step(2);
        check("R6 not yet after two edges", int'(clk_oe[0]), 1);
        step(1);
        check("R6 disabled floating", int'(clk_oe), 0);
        check("R6 disabled value", int'(clk_val), 0);
        oe_master_in = 1;
        step(3);
        check("R6 restored", int'(clk_oe), 5'b11011);
        pulse(2);
        check("R7 output high", int'(clk_val[0]), 1);
        oe_master_in = 0;
        step(6);
        check("R7 held while high oe", int'(clk_oe[0]), 1);
        check("R7 held while high val", int'(clk_val[0]), 1);
        check("R7 low output disabled", int'(clk_oe[4]), 0);
        pulse(2);
        check("R7 falls while enabled oe", int'(clk_oe[0]), 1);
        check("R7 falls while enabled val", int'(clk_val[0]), 0);
        step(1);
        check("R7 disabled after fall", int'(clk_oe[0]), 0);
        oe_master_in = 1;
        step(4);
        wr(4'hD, 8'h01);
        step(12);
        oe_master_in = 0;
        step(4);
        check("R6 driven low enable", int'(clk_oe), 5'b11011);
        check("R6 driven low value", int'(clk_val), 0);
        oe_master_in = 1;
        step(4);

        // R8: power-down on pad 2
        do_reset();
        wr(4'h6, 8'h02);
        step(2);
        pulse(0);
        check("R8 output 4 running", int'(clk_val[4]), 1);
        pwr_on_in = 0;
        #1;
        check("R8 core off at once", int'({osc_en, pll_en, div_en}), 0);
        check("R8 floating pads", int'(clk_oe), 0);
        check("R8 pad values", int'(clk_val), 0);
        step(1);
        wr(4'hD, 8'h02);
        step(12);
        check("R8 R5 driven low pads", int'(clk_oe), 5'b11011);
        check("R8 driven low values", int'(clk_val), 0);
        pwr_on_in = 1;
        #1;
        check("R8 core back on", int'({osc_en, pll_en, div_en}), 4'hF);
        check("R8 divider cleared", int'(clk_val[4]), 0);
        step(1);
        pulse(0);
        check("R8 restart from zero", int'(clk_val[4]), 1);

        // R9, R10, R13: configuration select on pad 4
        do_reset();
        wr(4'h0, 8'h02);
        wr(4'h8, 8'h03);
        wr(4'h7, 8'h04);
        wr(4'h6, 8'h03);
        step(20);
        check("R9 pad 4 input", int'(clk_oe[4]), 0);
        pulse(2); pulse(2);
        check("R9 set 1 two ticks", int'(clk_val[0]), 0);
        pulse(2);
        check("R9 set 1 third tick", int'(clk_val[0]), 1);
        cfg_sel_in = 0;
        step(2);
        cfg_sel_in = 1;
        step(20);
        pulse(2); pulse(2);
        check("R10 glitch ignored held", int'(clk_val[0]), 1);
        pulse(2);
        check("R10 glitch ignored toggle", int'(clk_val[0]), 0);
        cfg_sel_in = 0;
        step(20);
        pulse(2);
        check("R9 set 0 one tick", int'(clk_val[0]), 0);
        pulse(2);
        check("R9 set 0 two ticks", int'(clk_val[0]), 1);
        wr(4'h0, 8'h01);
        step(20);
        pulse(2);
        check("R13 applied set rewritten", int'(clk_val[0]), 0);
        pulse(2);
        check("R13 applied set toggles", int'(clk_val[0]), 1);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule